// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block carries out one read from a serial NOR flash. A pulse on `start_i` captures a 24-bit byte address, a byte count and a dual-mode flag. The block then selects the flash and sends the read command on MOSI. It clocks in the requested number of bytes and hands each one out on a byte stream with a one-cycle valid. When the read ends it deselects the flash and pulses `done_o`.

In normal mode the command is a plain read: one opcode byte and three address bytes. In dual mode the command is a fast read, which adds one zero dummy byte. In both modes the opcode, address and dummy byte go out on MOSI alone. Only the data phase changes with the mode. In dual mode the flash returns two bits on each clock, and the block releases its MOSI driver so that the flash can drive the shared line. The serial clock idles low; MOSI changes on the falling edge and inputs are sampled on the rising edge. The clock half-period is `SCK_HALF` system cycles. An abort input ends a read at once.

Top module: `spi_flash_rd_seq`

## Requirements
- R1: While reset is held and after it is released, `cs_o` sits at the `cs_idle_i` level, and `sck_o`, `done_o`, `rd_valid_o` and `mosi_oe_o` are all low.
- R2: With `dual_i` low, MOSI carries opcode 0x03 and then address bits 23:16, 15:8 and 7:0. Every byte goes out MSB first over 32 SCK rising edges, and MOSI never changes while SCK is high.
- R3: With `dual_i` high, MOSI carries opcode 0x3B, then the same three address bytes, then a 0x00 dummy byte, over 40 SCK rising edges.
- R4: In normal mode each data byte takes 8 SCK clocks. It is sampled from `io1_i` on the rising edges, MSB first.
- R5: In dual mode each data byte takes 4 SCK clocks. `io1_i` carries bits 7, 5, 3 and 1, and `io0_i` carries bits 6, 4, 2 and 0, in that order. `mosi_oe_o` is low throughout the dual data phase.
- R6: Exactly `len_i` bytes appear on `rd_data_o`, each with `rd_valid_o` high for one cycle. They come in ascending address order, starting at `addr_i`.
- R7: The flash stays selected from the cycle after a start is accepted until the last data clock has ended. SCK is low whenever the flash is not selected.
- R8: `done_o` is a one-cycle pulse, once per read, in the same cycle that `cs_o` returns to the `cs_idle_i` level.
- R9: A count of zero sends only the command bytes, with no data clocks and no `rd_valid_o`, and then pulses `done_o`.
- R10: `abort_i` during a read deselects the flash and stops SCK on the next edge. It also pulses `done_o` once, and no further byte is delivered.
- R11: `start_i` has no effect while a read is in progress. The address, mode and count of the current read stay in force.
- R12: The selected level of `cs_o` is the inverse of `cs_idle_i`: active low when `cs_idle_i` is 1, and active high when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read (taken only when idle) |
| addr_i | input | 24 | First flash byte address |
| len_i | input | LEN_W | Number of data bytes to read |
| dual_i | input | 1 | Select the dual-output fast read |
| cs_idle_i | input | 1 | Level of chip select when deselected |
| abort_i | input | 1 | Stop the current read at once |
| rd_data_o | output | 8 | Received data byte |
| rd_valid_o | output | 1 | `rd_data_o` holds a new byte this cycle |
| done_o | output | 1 | One-cycle end-of-read pulse |
| sck_o | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi_o | output | 1 | Command/address data to the flash |
| mosi_oe_o | output | 1 | Drive enable for the MOSI/IO0 line |
| io0_i | input | 1 | Flash IO0 (used in dual data phase) |
| io1_i | input | 1 | Flash IO1 / MISO |

## Verification
A behavioural flash model answers on SCK edges. It decodes the opcode to choose the command length and data width. It returns bytes computed from the address, so a wrong address, a wrong bit pairing or a wrong byte order shows up as wrong data. The main read is run over a table that mixes both modes, both chip-select polarities, single-byte and multi-byte counts, and an address near the top of the 24-bit space. The edge count tells a missing or extra dummy byte apart from a data-width error. Directed cases cover a zero count in each mode, an abort after two bytes, and a second start pulse with a changed address and mode partway through a read.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_END
  } seq_state_e;

  localparam logic [7:0] OPC_READ      = 8'h03;
  localparam logic [7:0] OPC_READ_DUAL = 8'h3B;
  localparam int         ADDR_W        = 24;

  // number of bytes in the command phase for the chosen mode
  function automatic logic [2:0] cmd_bytes(input logic dual);
    return dual ? 3'd5 : 3'd4;
  endfunction

  // command byte at position idx: opcode, addr high/mid/low, dummy
  function automatic logic [7:0] cmd_byte(input logic [2:0] idx,
                                          input logic [ADDR_W-1:0] addr,
                                          input logic dual);
    logic [7:0] b;
    case (idx)
      3'd0:    b = dual ? OPC_READ_DUAL : OPC_READ;
      3'd1:    b = addr[23:16];
      3'd2:    b = addr[15:8];
      3'd3:    b = addr[7:0];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  // serial clocks needed for one byte
  function automatic logic [3:0] clocks_per_byte(input logic dual);
    return dual ? 4'd4 : 4'd8;
  endfunction

endpackage

// File: rtl/sfr_sck_gen.sv
module sfr_sck_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic rise_ev_o,
  output logic fall_ev_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap      = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_ev_o = wrap && !sck_o;
  assign fall_ev_o = wrap && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // every edge event alternates: a rise can only follow a low clock
  assert_rise_from_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev_o |=> sck_o);

endmodule

// File: rtl/sfr_byte_shift.sv
module sfr_byte_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       load_dual_i,
  input  logic [7:0] tx_byte_i,
  input  logic       kill_i,
  input  logic       rise_ev_i,
  input  logic       fall_ev_i,
  input  logic       io0_i,
  input  logic       io1_i,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o
);
  import sfr_pkg::*;

  logic [7:0] tx_sh_q;
  logic [7:0] rx_sh_q;
  logic [3:0] clk_cnt_q;
  logic       dual_q;
  logic       last_clk_seen;

  assign last_clk_seen = (clk_cnt_q == clocks_per_byte(dual_q));
  assign byte_done_o   = busy_o && fall_ev_i && last_clk_seen;
  assign mosi_o        = tx_sh_q[7];
  assign rx_byte_o     = rx_sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      clk_cnt_q <= '0;
      dual_q    <= 1'b0;
      busy_o    <= 1'b0;
    end else if (kill_i) begin
      busy_o  <= 1'b0;
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q   <= tx_byte_i;
      clk_cnt_q <= '0;
      dual_q    <= load_dual_i;
      busy_o    <= 1'b1;
    end else if (busy_o) begin
      if (rise_ev_i) begin
        clk_cnt_q <= clk_cnt_q + 4'd1;
        if (dual_q) rx_sh_q <= {rx_sh_q[5:0], io1_i, io0_i};
        else        rx_sh_q <= {rx_sh_q[6:0], io1_i};
      end
      if (fall_ev_i) begin
        tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        if (last_clk_seen) busy_o <= 1'b0;
      end
    end
  end

  assert_clk_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && rise_ev_i) |-> (clk_cnt_q < clocks_per_byte(dual_q)));

  assert_no_edges_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rise_ev_i || fall_ev_i));

endmodule

// File: rtl/spi_flash_rd_seq.sv
module spi_flash_rd_seq #(
  parameter int LEN_W    = 16,
  parameter int SCK_HALF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [23:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dual_i,
  input  logic             cs_idle_i,
  input  logic             abort_i,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  output logic             done_o,
  output logic             sck_o,
  output logic             cs_o,
  output logic             mosi_o,
  output logic             mosi_oe_o,
  input  logic             io0_i,
  input  logic             io1_i
);
  import sfr_pkg::*;

  seq_state_e       state_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic             dual_q;
  logic [2:0]       idx_q;
  logic             cs_act_q;

  // internal events, named for the assertions
  logic       sck_rise, sck_fall;
  logic       shift_busy, byte_done, shift_mosi;
  logic [7:0] rx_byte;
  logic       accept, kill, last_cmd, last_data, no_data;
  logic       load, load_dual;
  logic [7:0] tx_byte;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign kill      = abort_i && ((state_q == ST_CMD) || (state_q == ST_DATA));
  assign last_cmd  = (idx_q == (cmd_bytes(dual_q) - 3'd1));
  assign last_data = (left_q == LEN_W'(1));
  assign no_data   = (left_q == '0);

  always_comb begin
    load      = 1'b0;
    load_dual = 1'b0;
    tx_byte   = 8'h00;
    if (accept) begin
      load    = 1'b1;
      tx_byte = cmd_byte(3'd0, addr_i, dual_i);
    end else if (!kill && byte_done) begin
      if (state_q == ST_CMD) begin
        if (!last_cmd) begin
          load    = 1'b1;
          tx_byte = cmd_byte(idx_q + 3'd1, addr_q, dual_q);
        end else if (!no_data) begin
          load      = 1'b1;
          load_dual = dual_q;
        end
      end else if ((state_q == ST_DATA) && !last_data) begin
        load      = 1'b1;
        load_dual = dual_q;
      end
    end
  end

  sfr_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (shift_busy && !kill),
    .sck_o     (sck_o),
    .rise_ev_o (sck_rise),
    .fall_ev_o (sck_fall)
  );

  sfr_byte_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .load_dual_i (load_dual),
    .tx_byte_i   (tx_byte),
    .kill_i      (kill),
    .rise_ev_i   (sck_rise),
    .fall_ev_i   (sck_fall),
    .io0_i       (io0_i),
    .io1_i       (io1_i),
    .mosi_o      (shift_mosi),
    .busy_o      (shift_busy),
    .byte_done_o (byte_done),
    .rx_byte_o   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      left_q     <= '0;
      dual_q     <= 1'b0;
      idx_q      <= '0;
      cs_act_q   <= 1'b0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q   <= addr_i;
            left_q   <= len_i;
            dual_q   <= dual_i;
            idx_q    <= '0;
            cs_act_q <= 1'b1;
            state_q  <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (kill) begin
            cs_act_q <= 1'b0;
            done_o   <= 1'b1;
            state_q  <= ST_END;
          end else if (byte_done) begin
            if (!last_cmd) begin
              idx_q <= idx_q + 3'd1;
            end else if (no_data) begin
              cs_act_q <= 1'b0;
              done_o   <= 1'b1;
              state_q  <= ST_END;
            end else begin
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (kill) begin
            cs_act_q <= 1'b0;
            done_o   <= 1'b1;
            state_q  <= ST_END;
          end else if (byte_done) begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= rx_byte;
            left_q     <= left_q - LEN_W'(1);
            if (last_data) begin
              cs_act_q <= 1'b0;
              done_o   <= 1'b1;
              state_q  <= ST_END;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_o      = cs_act_q ? ~cs_idle_i : cs_idle_i;
  assign mosi_o    = cs_act_q && shift_mosi;
  assign mosi_oe_o = cs_act_q && !((state_q == ST_DATA) && dual_q);

  assert_sck_low_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act_q |-> !sck_o);

  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_with_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_o == cs_idle_i));

  assert_mosi_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && start_i) |=> ($stable(addr_q) && $stable(dual_q)));

  assert_valid_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> ($past(state_q) == ST_DATA));

  assert_dual_releases_io0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DATA) && dual_q) |-> !mosi_oe_o);

  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (done_o && !sck_o));

endmodule

// File: tb/tb_spi_flash_rd_seq.sv
module tb_spi_flash_rd_seq;

  localparam int LEN_W = 16;
  localparam int HALF  = 2;

  typedef struct packed {
    logic [23:0] a;
    logic [15:0] n;
    logic        d;
    logic        p;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{a: 24'h000000, n: 16'd1, d: 1'b0, p: 1'b1},
    '{a: 24'hABCDEF, n: 16'd5, d: 1'b0, p: 1'b1},
    '{a: 24'h123456, n: 16'd4, d: 1'b1, p: 1'b1},
    '{a: 24'hFFFFFE, n: 16'd3, d: 1'b1, p: 1'b0},
    '{a: 24'h800001, n: 16'd2, d: 1'b0, p: 1'b0},
    '{a: 24'h5A5A5A, n: 16'd7, d: 1'b1, p: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic dual_i = 1'b0;
  logic cs_idle_i = 1'b1;
  logic abort_i = 1'b0;
  logic io0_i = 1'b0;
  logic io1_i = 1'b0;
  logic [7:0] rd_data_o;
  logic rd_valid_o, done_o, sck_o, cs_o, mosi_o, mosi_oe_o;

  always #10 clk = ~clk;

  spi_flash_rd_seq #(.LEN_W(LEN_W), .SCK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .dual_i(dual_i), .cs_idle_i(cs_idle_i), .abort_i(abort_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
    .sck_o(sck_o), .cs_o(cs_o), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o),
    .io0_i(io0_i), .io1_i(io1_i)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd7;
    return m ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'hA5;
  endfunction

  // flash model and monitor state
  logic        prev_sck = 1'b0;
  logic        prev_mosi = 1'b0;
  int          rises;
  logic [39:0] cmd_sh;
  logic        model_dual;
  int          bits_needed;
  bit          cmd_done;
  logic [23:0] m_addr;
  int          k;
  int          sub;
  logic [7:0]  sh;
  logic [7:0]  got [0:31];
  int          ngot;
  int          dones;
  int          sel_cycles;
  bit          cs_bad_at_done, oe_bad, mosi_bad, sck_bad;

  task automatic mon_clear();
    rises = 0; cmd_sh = '0; model_dual = 1'b0; bits_needed = 40; cmd_done = 1'b0;
    m_addr = '0; k = 0; sub = 0; sh = '0; ngot = 0; dones = 0; sel_cycles = 0;
    cs_bad_at_done = 1'b0; oe_bad = 1'b0; mosi_bad = 1'b0; sck_bad = 1'b0;
  endtask

  initial begin
    mon_clear();
    forever begin
      @(negedge clk);
      if (cs_o !== cs_idle_i) sel_cycles++;
      if (sck_o && !prev_sck) begin
        if (cs_o === cs_idle_i) sck_bad = 1'b1;
        rises++;
        if (!cmd_done) begin
          cmd_sh = {cmd_sh[38:0], mosi_o};
          if (rises == 8) begin
            model_dual  = (cmd_sh[7:0] == 8'h3B);
            bits_needed = model_dual ? 40 : 32;
          end
          if (rises == bits_needed) begin
            cmd_done = 1'b1;
            m_addr   = model_dual ? cmd_sh[31:8] : cmd_sh[23:0];
          end
        end
      end
      if (prev_sck && !sck_o && cmd_done) begin
        if (sub == 0) begin
          sh = mem_byte(m_addr + 24'(k));
          k++;
        end
        if (model_dual) begin
          io1_i = sh[7]; io0_i = sh[6]; sh = {sh[5:0], 2'b00}; sub = (sub + 1) % 4;
        end else begin
          io1_i = sh[7]; io0_i = 1'b0; sh = {sh[6:0], 1'b0}; sub = (sub + 1) % 8;
        end
      end
      if (sck_o && prev_sck && (mosi_o !== prev_mosi)) mosi_bad = 1'b1;
      if (cmd_done && model_dual && (rises > bits_needed) &&
          (cs_o !== cs_idle_i) && mosi_oe_o) oe_bad = 1'b1;
      if (rd_valid_o) begin
        if (ngot < 32) got[ngot] = rd_data_o;
        ngot++;
      end
      if (done_o) begin
        dones++;
        if (cs_o !== cs_idle_i) cs_bad_at_done = 1'b1;
      end
      prev_sck  = sck_o;
      prev_mosi = mosi_o;
    end
  end

  // run one read; poke_at injects a start pulse, abort_at aborts after N bytes
  task automatic run_xfer(input logic [23:0] a, input int n, input logic d,
                          input logic p, input int poke_at, input int abort_at);
    int t;
    bit aborted;
    cs_idle_i = p;
    repeat (3) @(negedge clk);
    mon_clear();
    addr_i = a; len_i = LEN_W'(n); dual_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0;
    aborted = 1'b0;
    while (dones == 0 && t < 5000) begin
      @(negedge clk);
      t++;
      start_i = 1'b0;
      abort_i = 1'b0;
      if (t == poke_at) begin
        start_i = 1'b1; addr_i = ~a; dual_i = ~d; len_i = LEN_W'(n + 3);
      end
      if (abort_at >= 0 && !aborted && ngot == abort_at) begin
        abort_i = 1'b1; aborted = 1'b1;
      end
    end
    start_i = 1'b0;
    abort_i = 1'b0;
    repeat (abort_at >= 0 ? 60 : 4) @(negedge clk);
  endtask

  task automatic check_full(input logic [23:0] a, input int n, input logic d,
                            input logic p);
    string rq;
    rq = d ? "R5" : "R4";
    if (d) begin
      chk(cmd_sh[39:32] == 8'h3B, "R3", "opcode", cmd_sh[39:32], 8'h3B);
      chk(cmd_sh[31:8] == a, "R3", "address", cmd_sh[31:8], a);
      chk(cmd_sh[7:0] == 8'h00, "R3", "dummy byte", cmd_sh[7:0], 0);
      chk(!oe_bad, "R5", "mosi_oe low in data phase", oe_bad, 0);
    end else begin
      chk(cmd_sh[31:24] == 8'h03, "R2", "opcode", cmd_sh[31:24], 8'h03);
      chk(cmd_sh[23:0] == a, "R2", "address", cmd_sh[23:0], a);
    end
    chk(!mosi_bad, "R2", "mosi stable while sck high", mosi_bad, 0);
    chk(rises == (d ? 40 : 32) + n * (d ? 4 : 8), rq, "sck rising edges",
        rises, (d ? 40 : 32) + n * (d ? 4 : 8));
    chk(ngot == n, "R6", "byte count", ngot, n);
    for (int i = 0; i < n && i < 32; i++)
      chk(got[i] == mem_byte(a + 24'(i)), rq, "data byte", got[i], mem_byte(a + 24'(i)));
    chk(dones == 1 && !cs_bad_at_done, "R8", "done pulse with release",
        dones, 1);
    chk(!sck_bad, "R7", "sck only while selected", sck_bad, 0);
    chk(cs_o == p && sel_cycles > 0, "R12", "select polarity", cs_o, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual 150000 cycles expected completion earlier");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs_o == 1'b1 && !sck_o && !done_o && !rd_valid_o && !mosi_oe_o,
        "R1", "outputs in reset", {cs_o, sck_o, done_o, rd_valid_o, mosi_oe_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_o == 1'b1 && !sck_o && !done_o && !rd_valid_o && !mosi_oe_o,
        "R1", "outputs after reset", {cs_o, sck_o, done_o, rd_valid_o, mosi_oe_o}, 5'b10000);

    // table-driven reads covering R2..R8, R12
    for (int i = 0; i < NV; i++) begin
      run_xfer(VECS[i].a, int'(VECS[i].n), VECS[i].d, VECS[i].p, -1, -1);
      check_full(VECS[i].a, int'(VECS[i].n), VECS[i].d, VECS[i].p);
    end

    // R9: zero count in both modes
    run_xfer(24'h001234, 0, 1'b0, 1'b1, -1, -1);
    chk(rises == 32 && ngot == 0 && dones == 1, "R9", "zero count single",
        {rises[15:0], ngot[15:0], dones[15:0]}, {16'd32, 16'd0, 16'd1});
    run_xfer(24'h00ABCD, 0, 1'b1, 1'b1, -1, -1);
    chk(rises == 40 && ngot == 0 && dones == 1, "R9", "zero count dual",
        {rises[15:0], ngot[15:0], dones[15:0]}, {16'd40, 16'd0, 16'd1});

    // R11: a start pulse mid-read changes nothing
    run_xfer(24'h3C3C3C, 3, 1'b0, 1'b1, 40, -1);
    check_full(24'h3C3C3C, 3, 1'b0, 1'b1);
    chk(ngot == 3 && dones == 1, "R11", "mid-read start ignored", ngot, 3);

    // R10: abort after two bytes
    run_xfer(24'h0F0F00, 10, 1'b0, 1'b1, -1, 2);
    chk(ngot == 2, "R10", "no byte after abort", ngot, 2);
    chk(dones == 1, "R10", "single done on abort", dones, 1);
    chk(cs_o == 1'b1 && !sck_o, "R10", "released after abort", {cs_o, sck_o}, 2'b10);
    chk(rises < 32 + 80, "R10", "clock stopped early", rises, 32 + 80);

    // read still works after an abort
    run_xfer(24'h010203, 2, 1'b1, 1'b1, -1, -1);
    check_full(24'h010203, 2, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule